// File: doc/BRIEF.md
# Sync Word Correlator with Byte Framer

This block sits after bit recovery in a receive path. It watches a stream of demodulated bits, each marked by a one-cycle valid strobe. On every valid bit it compares the newest bits against a programmable 16-bit sync word, or against that word written twice as a 32-bit pattern. A number of mismatching bits can be tolerated, depending on the mode. A match can also be made to depend on a carrier-sense flag, a preamble-quality flag, or both. A qualified match gives a one-cycle detection pulse. The match point fixes the byte boundaries: the bits that follow the last sync bit are packed into bytes, most significant bit first, until a programmed number of bytes has been delivered or an abort arrives. The block then goes back to searching.

The controller has three states:
- `ST_OFF`: the mode code disables detection.
- `ST_HUNT`: the block is searching.
- `ST_FRAME`: the block is delivering bytes.

The transitions are:
- OFF→HUNT when the mode enables a threshold.
- HUNT→OFF when the mode disables it.
- HUNT→FRAME on a qualified match with a non-zero byte count.
- FRAME→HUNT either on abort or on the last bit of the last byte.

The mode code is 3 bits. Bits [1:0] select the threshold: 00 disabled, 01 at least 15 of 16, 10 all 16 of 16, 11 at least 30 of 32. Bit 2 adds the carrier-sense requirement.

Top module: `sync_correlator`

## Requirements
- R1: While reset is held, and right after it is released, `sync_det`, `byte_vld` and `locked` are all 0.
- R2: In mode 010 a match needs the 16 most recent valid bits to equal `sync_word`, with the newest bit compared against bit 0. `sync_det` is high during the cycle in which the completing bit is presented with `bit_vld`, and is never high without `bit_vld`. A single wrong bit prevents detection.
- R3: In mode 001 a window with one wrong bit out of 16 is detected, and a window with two wrong bits is not.
- R4: In mode 011 the pattern is `{sync_word, sync_word}`. A window with up to two wrong bits out of 32 is detected, and a window with three wrong bits is not.
- R5: No detection happens until at least 16 valid bits (16-bit modes) or 32 valid bits (mode 011) have arrived since reset, even when the window register's reset contents would match.
- R6: With mode bits [1:0] = 00 and the block unlocked, `sync_det` stays low and `locked` never rises.
- R7: With mode bit 2 set, a match counts only if `carrier_ok` is high in the same cycle.
- R8: With `pqt_en` high, a match counts only if `pqt_ok` is high in the same cycle.
- R9: After a detection with `pkt_len` ≠ 0, `locked` is high from the next cycle on. The bits that follow are grouped into bytes, first bit in bit 7. After each eighth bit, `byte_vld` pulses for one cycle together with `byte_out`.
- R10: `locked` falls in the cycle after the last bit of byte number `pkt_len`, which is the same cycle in which that byte is delivered, and the search resumes. A detection with `pkt_len` = 0 pulses `sync_det` and does not lock.
- R11: While `locked` is high, no search is made: a sync word inside the data gives no `sync_det` and is delivered as data.
- R12: `abort` while locked drops `locked` in the next cycle and throws away the partial byte, with no `byte_vld`. `abort` while unlocked has no effect on the search.
- R13: `bit_in` is ignored in every cycle in which `bit_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Demodulated data bit |
| bit_vld | input | 1 | Strobe marking a new bit |
| sync_word | input | 16 | Programmable sync word |
| mode | input | 3 | [1:0] threshold select, [2] carrier-sense requirement |
| pqt_en | input | 1 | Require preamble quality for a match |
| pqt_ok | input | 1 | Preamble quality reached |
| carrier_ok | input | 1 | Carrier sense present |
| pkt_len | input | 8 | Number of bytes to frame after detection |
| abort | input | 1 | End framing early |
| sync_det | output | 1 | Qualified match pulse |
| byte_out | output | 8 | Framed byte |
| byte_vld | output | 1 | Byte strobe |
| locked | output | 1 | Framing in progress |

## Verification
The bench builds the block with its default parameters: a 16-bit word, which gives a 32-bit window, 8-bit bytes and an 8-bit length counter. With these sizes every threshold can be placed exactly at its edge, by flipping one bit more or one bit fewer than allowed. An all-zero sync word matched against the zeroed window register, at exactly 15/16 and 31/32 bits, shows that detection is held off until the window is filled. Short byte counts of 0 to 4 are enough to reach normal completion, the zero-length case, and an abort in the middle of a byte.

// File: rtl/syncw_pkg.sv
package syncw_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_HUNT  = 2'd1,
        ST_FRAME = 2'd2
    } sc_state_t;

    typedef enum logic [1:0] {
        TH_NONE   = 2'b00,
        TH_15OF16 = 2'b01,
        TH_16OF16 = 2'b10,
        TH_30OF32 = 2'b11
    } thr_sel_t;

endpackage

// File: rtl/syncw_history.sv
module syncw_history #(
    parameter int WORD_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bit_vld,
    input  logic                  bit_in,
    output logic [2*WORD_W-1:0]   window,
    output logic                  have_half,
    output logic                  have_full
);
    localparam int WIN_W  = 2 * WORD_W;
    localparam int FILL_W = $clog2(WIN_W + 1);

    logic [WIN_W-1:0]  hist_q;
    logic [FILL_W-1:0] fill_q;

    // window including the bit being presented now
    assign window    = {hist_q[WIN_W-2:0], bit_in};
    assign have_half = (fill_q >= FILL_W'(WORD_W - 1));
    assign have_full = (fill_q >= FILL_W'(WIN_W - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
            fill_q <= '0;
        end else if (bit_vld) begin
            hist_q <= window;
            if (fill_q != FILL_W'(WIN_W))
                fill_q <= fill_q + 1'b1;
        end
    end

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= FILL_W'(WIN_W)) else $error("fill overflow"); // R5

endmodule

// File: rtl/syncw_matcher.sv
module syncw_matcher
    import syncw_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic [2*WORD_W-1:0] window,
    input  logic [WORD_W-1:0]   word,
    input  thr_sel_t            sel,
    input  logic                have_half,
    input  logic                have_full,
    output logic                hit
);
    localparam int CNT_W     = $clog2(2 * WORD_W + 1);
    localparam int NEED_LOOS = WORD_W - 1;
    localparam int NEED_EXCT = WORD_W;
    localparam int NEED_LONG = 2 * WORD_W - 2;

    logic [CNT_W-1:0] agree_lo;
    logic [CNT_W-1:0] agree_hi;
    logic [CNT_W-1:0] agree_all;

    always_comb begin
        agree_lo = '0;
        agree_hi = '0;
        for (int i = 0; i < WORD_W; i++) begin
            agree_lo = agree_lo + {{(CNT_W-1){1'b0}}, window[i] ~^ word[i]};
            agree_hi = agree_hi + {{(CNT_W-1){1'b0}}, window[i+WORD_W] ~^ word[i]};
        end
        agree_all = agree_lo + agree_hi;
    end

    always_comb begin
        unique case (sel)
            TH_15OF16: hit = have_half && (agree_lo  >= CNT_W'(NEED_LOOS));
            TH_16OF16: hit = have_half && (agree_lo  == CNT_W'(NEED_EXCT));
            TH_30OF32: hit = have_full && (agree_all >= CNT_W'(NEED_LONG));
            default:   hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/syncw_framer.sv
module syncw_framer #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              run,
    input  logic              bit_in,
    output logic              last_bit,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_vld
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] shift_q;
    logic [BYTE_W-1:0] byte_q;
    logic              vld_q;

    assign last_bit = (cnt_q == CNT_W'(BYTE_W - 1));
    assign byte_out = byte_q;
    assign byte_vld = vld_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shift_q <= '0;
            byte_q  <= '0;
            vld_q   <= 1'b0;
        end else if (flush) begin
            cnt_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= run && last_bit;
            if (run) begin
                shift_q <= {shift_q[BYTE_W-2:0], bit_in};
                cnt_q   <= last_bit ? '0 : cnt_q + 1'b1;
                if (last_bit)
                    byte_q <= {shift_q[BYTE_W-2:0], bit_in};
            end
        end
    end

    AST_BYTE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld) else $error("byte strobe too long"); // R9

endmodule

// File: rtl/sync_correlator.sv
module sync_correlator
    import syncw_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              bit_vld,
    input  logic [WORD_W-1:0] sync_word,
    input  logic [2:0]        mode,
    input  logic              pqt_en,
    input  logic              pqt_ok,
    input  logic              carrier_ok,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic              abort,
    output logic              sync_det,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_vld,
    output logic              locked
);
    localparam int WIN_W = 2 * WORD_W;

    sc_state_t          state_q, state_d;
    logic [LEN_W-1:0]   left_q;
    logic [WIN_W-1:0]   window;
    logic               have_half, have_full;
    logic               hit, qual, det;
    logic               enabled, run, flush, last_bit, byte_done;
    thr_sel_t           sel;

    assign sel       = thr_sel_t'(mode[1:0]);
    assign enabled   = (mode[1:0] != 2'b00);
    assign qual      = (!mode[2] || carrier_ok) && (!pqt_en || pqt_ok);
    assign det       = (state_q == ST_HUNT) && bit_vld && hit && qual;
    assign run       = (state_q == ST_FRAME) && bit_vld && !abort;
    assign byte_done = run && last_bit;
    assign flush     = (det && pkt_len != '0) || ((state_q == ST_FRAME) && abort);

    syncw_history #(.WORD_W(WORD_W)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_vld   (bit_vld),
        .bit_in    (bit_in),
        .window    (window),
        .have_half (have_half),
        .have_full (have_full)
    );

    syncw_matcher #(.WORD_W(WORD_W)) u_match (
        .window    (window),
        .word      (sync_word),
        .sel       (sel),
        .have_half (have_half),
        .have_full (have_full),
        .hit       (hit)
    );

    syncw_framer #(.BYTE_W(BYTE_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .run      (run),
        .bit_in   (bit_in),
        .last_bit (last_bit),
        .byte_out (byte_out),
        .byte_vld (byte_vld)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (enabled) state_d = ST_HUNT;
            ST_HUNT: begin
                if (!enabled)                    state_d = ST_OFF;
                else if (det && pkt_len != '0)   state_d = ST_FRAME;
            end
            ST_FRAME: begin
                if (abort)                                   state_d = ST_HUNT;
                else if (byte_done && left_q == LEN_W'(1))   state_d = ST_HUNT;
            end
            default:  state_d = ST_OFF;
        endcase
    end

    // state register and byte budget
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            if (det)
                left_q <= pkt_len;
            else if (byte_done)
                left_q <= left_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        sync_det = det;
        locked   = (state_q == ST_FRAME);
    end

    AST_DET_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        sync_det |-> bit_vld) else $error("detect without bit"); // R2
    AST_SILENT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && mode[1:0] == 2'b00) |-> !sync_det) else $error("detect while off"); // R6
    AST_DET_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_det && mode[2]) |-> carrier_ok) else $error("carrier ignored"); // R7
    AST_DET_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_det && pqt_en) |-> pqt_ok) else $error("preamble ignored"); // R8
    AST_DET_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_det && pkt_len != '0) |=> locked) else $error("no lock"); // R9
    AST_BYTE_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(bit_vld)) else $error("byte without bit"); // R9
    AST_NO_SEARCH_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !sync_det) else $error("search while locked"); // R11
    AST_ABORT_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && abort) |=> (!locked && !byte_vld)) else $error("abort ignored"); // R12

endmodule

// File: tb/sync_correlator_test.sv
module sync_correlator_test;

    localparam logic [15:0] W = 16'hD391;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_in = 1'b0;
    logic        bit_vld = 1'b0;
    logic [15:0] sync_word = W;
    logic [2:0]  mode = 3'b010;
    logic        pqt_en = 1'b0;
    logic        pqt_ok = 1'b0;
    logic        carrier_ok = 1'b0;
    logic [7:0]  pkt_len = 8'd0;
    logic        abort = 1'b0;
    logic        sync_det;
    logic [7:0]  byte_out;
    logic        byte_vld;
    logic        locked;

    int   n_chk = 0;
    int   n_fail = 0;
    int   det_cnt = 0;
    logic det_last = 1'b0;
    logic [7:0] rx_q[$];

    always #5 clk = ~clk;

    sync_correlator uut (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
        .sync_word(sync_word), .mode(mode), .pqt_en(pqt_en), .pqt_ok(pqt_ok),
        .carrier_ok(carrier_ok), .pkt_len(pkt_len), .abort(abort),
        .sync_det(sync_det), .byte_out(byte_out), .byte_vld(byte_vld),
        .locked(locked)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_in = b; bit_vld = 1'b1;
        #1;
        det_last = sync_det;
        if (sync_det) det_cnt++;
        @(posedge clk);
        #1;
        bit_vld = 1'b0;
        if (byte_vld) rx_q.push_back(byte_out);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic idle(input logic b);
        @(negedge clk);
        bit_in = b; bit_vld = 1'b0;
    endtask

    task automatic pulse_abort(output logic lk, output logic bv);
        @(negedge clk);
        abort = 1'b1;
        @(posedge clk);
        #1;
        lk = locked; bv = byte_vld;
        @(negedge clk);
        abort = 1'b0;
    endtask

    task automatic do_reset;
        rst_n = 1'b0; bit_vld = 1'b0; abort = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        det_cnt = 0; det_last = 1'b0;
        rx_q.delete();
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!sync_det && !byte_vld && !locked, "R1 in reset", {sync_det, byte_vld, locked}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!sync_det && !byte_vld && !locked, "R1 after release", {sync_det, byte_vld, locked}, 0);
    endtask

    task automatic t_exact;
        sync_word = W; mode = 3'b010; pkt_len = 0;
        do_reset();
        send_bits(W, 16);
        check(det_last && det_cnt == 1, "R2 exact match", det_cnt, 1);
        do_reset();
        send_bits(W ^ 16'h0100, 16);
        check(det_cnt == 0, "R2 one error rejected", det_cnt, 0);
    endtask

    task automatic t_loose;
        mode = 3'b001; pkt_len = 0;
        do_reset();
        send_bits(W ^ 16'h0100, 16);
        check(det_last == 1'b1, "R3 one error accepted", det_last, 1);
        do_reset();
        send_bits(W ^ 16'h0101, 16);
        check(det_cnt == 0, "R3 two errors rejected", det_cnt, 0);
    endtask

    task automatic t_long;
        mode = 3'b011; pkt_len = 0;
        do_reset();
        send_bits({W, W} ^ 32'h0001_0100, 32);
        check(det_last == 1'b1, "R4 two errors accepted", det_last, 1);
        do_reset();
        send_bits({W, W} ^ 32'h0101_0100, 32);
        check(det_cnt == 0, "R4 three errors rejected", det_cnt, 0);
    endtask

    task automatic t_fill;
        sync_word = 16'h0000; mode = 3'b010; pkt_len = 0;
        do_reset();
        send_bits(0, 15);
        check(det_cnt == 0, "R5 15 bits not enough", det_cnt, 0);
        send_bit(1'b0);
        check(det_last == 1'b1, "R5 16th bit detects", det_last, 1);
        mode = 3'b011;
        do_reset();
        send_bits(0, 31);
        check(det_cnt == 0, "R5 31 bits not enough", det_cnt, 0);
        send_bit(1'b0);
        check(det_last == 1'b1, "R5 32nd bit detects", det_last, 1);
        sync_word = W;
    endtask

    task automatic t_off;
        mode = 3'b000; pkt_len = 2;
        do_reset();
        send_bits(W, 16);
        check(det_cnt == 0 && !locked, "R6 disabled", {det_cnt[7:0], locked}, 0);
    endtask

    task automatic t_qual;
        mode = 3'b110; pkt_len = 0; carrier_ok = 1'b0;
        do_reset();
        send_bits(W, 16);
        check(det_cnt == 0, "R7 no carrier", det_cnt, 0);
        carrier_ok = 1'b1;
        do_reset();
        send_bits(W, 16);
        check(det_last == 1'b1, "R7 carrier present", det_last, 1);
        mode = 3'b010; carrier_ok = 1'b0; pqt_en = 1'b1; pqt_ok = 1'b0;
        do_reset();
        send_bits(W, 16);
        check(det_cnt == 0, "R8 no preamble quality", det_cnt, 0);
        pqt_ok = 1'b1;
        do_reset();
        send_bits(W, 16);
        check(det_last == 1'b1, "R8 preamble quality met", det_last, 1);
        pqt_en = 1'b0; pqt_ok = 1'b0;
    endtask

    task automatic t_frame;
        mode = 3'b010; pkt_len = 2;
        do_reset();
        send_bits(W, 16);
        check(det_last && locked, "R9 lock after detect", {det_last, locked}, 3);
        send_bits(8'h3C, 8);
        check(locked == 1'b1, "R9 still locked mid packet", locked, 1);
        send_bits(8'hA5, 8);
        check(rx_q.size() == 2, "R9 byte count", rx_q.size(), 2);
        if (rx_q.size() == 2) begin
            check(rx_q[0] == 8'h3C, "R9 first byte", rx_q[0], 8'h3C);
            check(rx_q[1] == 8'hA5, "R9 second byte", rx_q[1], 8'hA5);
        end
        check(locked == 1'b0, "R10 unlock after last byte", locked, 0);
        pkt_len = 0; det_cnt = 0;
        send_bits(W, 16);
        check(det_last && !locked, "R10 zero length resumes search", {det_last, locked}, 2);
    endtask

    task automatic t_no_search;
        mode = 3'b010; pkt_len = 3;
        do_reset();
        send_bits(W, 16);
        det_cnt = 0;
        send_bits({8'h00, W, 8'h00}, 24);
        check(det_cnt == 0, "R11 no detect while locked", det_cnt, 0);
        check(rx_q.size() == 3, "R11 bytes delivered", rx_q.size(), 3);
        if (rx_q.size() == 3)
            check(rx_q[0] == 8'hD3 && rx_q[1] == 8'h91 && rx_q[2] == 8'h00, "R11 sync as data",
                  {rx_q[0], rx_q[1], rx_q[2]}, 24'hD39100);
    endtask

    task automatic t_abort;
        logic lk, bv;
        mode = 3'b010; pkt_len = 4;
        do_reset();
        send_bits(W, 16);
        send_bits(4'b1010, 4);
        pulse_abort(lk, bv);
        check(!lk && !bv, "R12 abort unlocks", {lk, bv}, 0);
        send_bits(0, 12);
        check(rx_q.size() == 0 && !locked, "R12 partial byte dropped", rx_q.size(), 0);
        pkt_len = 0;
        do_reset();
        send_bits(W >> 8, 8);
        pulse_abort(lk, bv);
        send_bits(W[7:0], 8);
        check(det_last == 1'b1, "R12 abort ignored while hunting", det_last, 1);
    endtask

    task automatic t_gaps;
        mode = 3'b010; pkt_len = 0;
        do_reset();
        send_bits(W >> 8, 8);
        idle(1'b1); idle(1'b0); idle(1'b1);
        send_bits(W[7:0], 8);
        check(det_last && det_cnt == 1, "R13 bits without strobe ignored", det_cnt, 1);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_exact();
        t_loose();
        t_long();
        t_fill();
        t_off();
        t_qual();
        t_frame();
        t_no_search();
        t_abort();
        t_gaps();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule